// File: doc/BRIEF.md
# Dual-Edge ADC Sample Packer

This block sits directly behind a double-data-rate ADC receiver. The converter presents one sample on every rising and every falling edge of the capture clock. Each sample carries 14 data bits and an overrange flag. The block pairs the rising-edge sample with the falling-edge sample that follows it. It formats each of the two into a 16-bit lane and hands the resulting 32-bit word to a downstream FIFO, one write strobe per word.

A capture is armed by a rising edge on the capture-enable input while the block is idle. The sample target is latched at that moment, and the block takes whole pairs until the target is met. A capture can also end early, either through a forced-stop input or because capture-enable drops. In both cases the block emits a one-cycle done pulse and a status bit that tells an early stop apart from normal completion. If the FIFO is full when a word is ready, the word is dropped and a sticky overflow flag is raised.

Top module: `adc_pair_packer`

## Requirements
- R1: Each written word holds the rising-edge sample in bits [15:0] and the falling-edge sample that followed it in bits [31:16]. Each lane is laid out as {overrange, 1'b0, data[13:0]}, with the overrange bit at 15 and 31 and a zero at 14 and 30.
- R2: Within one capture, successive words carry successive sample pairs, with no sample lost, repeated or swapped between edges.
- R3: A capture starts only on a low-to-high change of cap_en seen while idle. Holding cap_en high after a capture has ended starts nothing further.
- R4: target_count is a sample count latched in the start cycle, so later changes have no effect on that capture. The capture writes target_count/2 words, with bit 0 ignored. A target below 2 ends at once with no words written.
- R5: cap_done is a one-cycle pulse given exactly once per capture. When the capture wrote any word, the pulse falls in the same cycle as the write strobe of the final word.
- R6: force_stop high at a rising edge during a capture ends it: no further pair is taken and stopped_early is set. The pair already in flight is still written. stopped_early is low after a normal completion and is cleared when the next capture starts.
- R7: cap_en low at a rising edge during a capture ends it in the same way as a forced stop.
- R8: fifo_wr stays low while fifo_full is high. A word that meets a full FIFO is dropped and sets overflow, which stays set until the next capture starts.
- R9: After reset, fifo_wr, cap_done, stopped_early and overflow are all low.
- R10: A forced stop that arrives after the final pair has been taken is ignored, and the capture completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; samples are taken on both edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_data | input | 14 | Converter data bits |
| adc_ovr | input | 1 | Converter overrange flag for the current sample |
| cap_en | input | 1 | Capture enable; its rising edge arms a capture |
| target_count | input | 16 | Number of samples to capture (bit 0 ignored) |
| force_stop | input | 1 | Ends a running capture early |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr | output | 1 | Write strobe, one cycle per packed word |
| fifo_wdata | output | 32 | Packed sample pair |
| cap_done | output | 1 | One-cycle pulse at the end of each capture |
| stopped_early | output | 1 | Last capture ended by force_stop or cap_en drop |
| overflow | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
The bench drives a ramp of sample indices across both clock edges, so every written word can be rebuilt from its own low lane. A design that swapped edge order, skipped a half-cycle or misplaced the overrange bit would produce a word that does not match that rebuilt value, or a jump between words. The stop cases aim at the boundaries of the pair counter. A stop on the first edge must write nothing. A stop on the last-take edge must lose exactly one pair. A stop one edge later must be ignored, and a design with an off-by-one in its counter or flush step would miscount words or flag an early stop wrongly. Odd and sub-two targets, a target changed in mid-capture, cap_en held high after completion, and a FIFO that stays full show up as wrong counts, a second done pulse, a spurious restart or an overflow flag that is lost or never cleared.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;

    // Defaults shared by the packer and its bench.
    localparam int DEF_DATA_W = 14;
    localparam int DEF_LANE_W = 16;
    localparam int DEF_CNT_W  = 16;
    localparam int LANES      = 2;

    // Capture sequencing.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } cap_state_e;

endpackage

// File: rtl/adc_fall_stage.sv
// Holds the falling-edge sample for half a cycle so that everything after it
// runs on the rising edge only.
module adc_fall_stage #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    output logic [W-1:0] smp_o
);

    logic [W-1:0] hold_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= smp_i;
    end

    assign smp_o = hold_q;

endmodule

// File: rtl/adc_word_pack.sv
// Registers the rising-edge sample, then on the next rising edge joins it with
// the held falling-edge sample into one word of LANES formatted lanes.
module adc_word_pack
    import adc_pack_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W:0]          smp_i,     // {ovr, data} live input
    input  logic [DATA_W:0]          fall_i,    // {ovr, data} falling-edge hold
    input  logic                     take_i,    // rising sample in rise_q belongs to a slot
    output logic [LANES*LANE_W-1:0]  word_o,
    output logic                     vld_o
);

    localparam int PAD_W  = LANE_W - DATA_W - 1;
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic [DATA_W:0] rise;
        logic [WORD_W-1:0] word;
        logic              vld;
    } pk_t;

    pk_t pk_d, pk_q;

    logic [LANES-1:0][DATA_W:0] lane_raw;
    logic [WORD_W-1:0]          word_cat;

    // Lane 0 is the earlier (rising) sample, lane 1 the later (falling) one.
    assign lane_raw[0] = pk_q.rise;
    assign lane_raw[1] = fall_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_cat[g*LANE_W +: LANE_W] =
            {lane_raw[g][DATA_W], {PAD_W{1'b0}}, lane_raw[g][DATA_W-1:0]};
    end

    always_comb begin
        pk_d      = pk_q;
        pk_d.rise = smp_i;
        pk_d.word = word_cat;
        pk_d.vld  = take_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_o = pk_q.word;
    assign vld_o  = pk_q.vld;

endmodule

// File: rtl/adc_cap_ctrl.sv
// Arming, pair counting, stop handling, done pulse and status flags.
module adc_cap_ctrl
    import adc_pack_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en_i,
    input  logic             force_stop_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic             word_vld_i,
    input  logic             fifo_full_i,
    output logic             take_o,
    output logic             done_o,
    output logic             early_o,
    output logic             ovf_o
);

    typedef struct packed {
        cap_state_e       st;
        logic             en_prev;
        logic [CNT_W-1:0] rem;
        logic             take;
        logic             done;
        logic             early;
        logic             ovf;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [CNT_W-1:0] pairs_req;
    logic             arm_edge;
    logic             stop_req;

    assign pairs_req = target_i >> 1;
    assign arm_edge  = cap_en_i && !c_q.en_prev;
    assign stop_req  = force_stop_i || !cap_en_i;

    always_comb begin
        c_d         = c_q;
        c_d.en_prev = cap_en_i;
        c_d.take    = 1'b0;
        c_d.done    = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (arm_edge) begin
                    c_d.early = 1'b0;
                    c_d.ovf   = 1'b0;
                    if (pairs_req == '0) begin
                        c_d.done = 1'b1;
                    end else begin
                        c_d.rem = pairs_req;
                        c_d.st  = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (stop_req) begin
                    c_d.done  = 1'b1;
                    c_d.early = 1'b1;
                    c_d.st    = ST_IDLE;
                end else begin
                    c_d.take = 1'b1;
                    c_d.rem  = c_q.rem - 1'b1;
                    if (c_q.rem == CNT_W'(1)) c_d.st = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                // Last pair is being packed this edge; stop requests are moot.
                c_d.done = 1'b1;
                c_d.st   = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase

        if (word_vld_i && fifo_full_i) c_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign take_o  = c_q.take;
    assign done_o  = c_q.done;
    assign early_o = c_q.early;
    assign ovf_o   = c_q.ovf;

endmodule

// File: rtl/adc_pair_packer.sv
module adc_pair_packer
    import adc_pack_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int LANE_W = DEF_LANE_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       adc_data,
    input  logic                    adc_ovr,
    input  logic                    cap_en,
    input  logic [CNT_W-1:0]        target_count,
    input  logic                    force_stop,
    input  logic                    fifo_full,
    output logic                    fifo_wr,
    output logic [LANES*LANE_W-1:0] fifo_wdata,
    output logic                    cap_done,
    output logic                    stopped_early,
    output logic                    overflow
);

    localparam int SMP_W = DATA_W + 1;

    logic [SMP_W-1:0] smp_live;
    logic [SMP_W-1:0] smp_fall;
    logic             take;
    logic             word_vld;

    assign smp_live = {adc_ovr, adc_data};

    adc_fall_stage #(.W(SMP_W)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .smp_i (smp_live),
        .smp_o (smp_fall)
    );

    adc_word_pack #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (smp_live),
        .fall_i (smp_fall),
        .take_i (take),
        .word_o (fifo_wdata),
        .vld_o  (word_vld)
    );

    adc_cap_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_en_i     (cap_en),
        .force_stop_i (force_stop),
        .target_i     (target_count),
        .word_vld_i   (word_vld),
        .fifo_full_i  (fifo_full),
        .take_o       (take),
        .done_o       (cap_done),
        .early_o      (stopped_early),
        .ovf_o        (overflow)
    );

    assign fifo_wr = word_vld && !fifo_full;

endmodule

// File: rtl/adc_pair_packer_chk.sv
module adc_pair_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cap_en,
    input logic        fifo_full,
    input logic        fifo_wr,
    input logic [31:0] fifo_wdata,
    input logic        cap_done,
    input logic        stopped_early,
    input logic        overflow
);

    // R1: the padding bit of each lane is zero on every written word
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (!fifo_wdata[14] && !fifo_wdata[30]));

    // R5: done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> !cap_done);

    // R5: nothing is written in the cycle after done
    p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> !fifo_wr);

    // R6: early-stop status survives while no new capture can be armed
    p_early_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_early && !cap_en) |=> stopped_early);

    // R8: overflow only rises after a cycle with the FIFO full
    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(fifo_full));

    // R8: overflow is sticky while no new capture can be armed
    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !cap_en) |=> overflow);

endmodule

bind adc_pair_packer adc_pair_packer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap_en        (cap_en),
    .fifo_full     (fifo_full),
    .fifo_wr       (fifo_wr),
    .fifo_wdata    (fifo_wdata),
    .cap_done      (cap_done),
    .stopped_early (stopped_early),
    .overflow      (overflow)
);

// File: tb/adc_pair_packer_tb.sv
module adc_pair_packer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] adc_data = '0;
    logic        adc_ovr = 1'b0;
    logic        cap_en = 1'b0;
    logic [15:0] target_count = '0;
    logic        force_stop = 1'b0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [31:0] fifo_wdata;
    logic        cap_done;
    logic        stopped_early;
    logic        overflow;

    adc_pair_packer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .adc_data      (adc_data),
        .adc_ovr       (adc_ovr),
        .cap_en        (cap_en),
        .target_count  (target_count),
        .force_stop    (force_stop),
        .fifo_full     (fifo_full),
        .fifo_wr       (fifo_wr),
        .fifo_wdata    (fifo_wdata),
        .cap_done      (cap_done),
        .stopped_early (stopped_early),
        .overflow      (overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Sample ramp: index drives data, bit 2 of the index drives overrange.
    // Even indices land on rising edges, odd ones on falling edges.
    logic [13:0] sidx = '0;
    initial begin
        forever begin
            @(negedge clk); #1;
            adc_data = sidx; adc_ovr = sidx[2]; sidx = sidx + 14'd1;
            @(posedge clk); #1;
            adc_data = sidx; adc_ovr = sidx[2]; sidx = sidx + 14'd1;
        end
    end

    // Output monitor, sampled mid-cycle.
    int          mon_words;
    int          mon_dones;
    bit          mon_first;
    bit          mon_done_wr;
    logic [13:0] mon_prev;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (fifo_wr) begin
                    logic [13:0] lo, hi;
                    logic [31:0] exp_w;
                    lo    = fifo_wdata[13:0] & 14'h3FFE;
                    hi    = lo + 14'd1;
                    exp_w = {hi[2], 1'b0, hi, lo[2], 1'b0, lo};
                    chk(fifo_wdata == exp_w, "R1 word layout", fifo_wdata, exp_w);
                    if (!mon_first)
                        chk(fifo_wdata[13:0] == mon_prev + 14'd2, "R2 pair sequence",
                            32'(fifo_wdata[13:0]), 32'(mon_prev + 14'd2));
                    mon_prev  = fifo_wdata[13:0];
                    mon_first = 1'b0;
                    mon_words++;
                end
                if (cap_done) begin
                    mon_dones++;
                    mon_done_wr = fifo_wr;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD*100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    typedef struct packed {
        logic [15:0] tgt;
        logic [7:0]  stop_at;   // edge index after start carrying force_stop, 0 = none
        logic [7:0]  drop_at;   // edge index after start with cap_en low, 0 = none
        logic        full;
        logic [7:0]  exp_words;
        logic        exp_early;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'd8,  8'd0, 8'd0, 1'b0, 8'd4, 1'b0, 1'b0},  // R4 even target
        '{16'd7,  8'd0, 8'd0, 1'b0, 8'd3, 1'b0, 1'b0},  // R4 odd target
        '{16'd1,  8'd0, 8'd0, 1'b0, 8'd0, 1'b0, 1'b0},  // R4 below two
        '{16'd0,  8'd0, 8'd0, 1'b0, 8'd0, 1'b0, 1'b0},  // R4 zero
        '{16'd20, 8'd4, 8'd0, 1'b0, 8'd3, 1'b1, 1'b0},  // R6 mid stop
        '{16'd20, 8'd1, 8'd0, 1'b0, 8'd0, 1'b1, 1'b0},  // R6 stop on first edge
        '{16'd6,  8'd3, 8'd0, 1'b0, 8'd2, 1'b1, 1'b0},  // R6 stop on last-take edge
        '{16'd6,  8'd4, 8'd0, 1'b0, 8'd3, 1'b0, 1'b0},  // R10 stop during flush
        '{16'd16, 8'd0, 8'd3, 1'b0, 8'd2, 1'b1, 1'b0},  // R7 enable dropped
        '{16'd6,  8'd0, 8'd0, 1'b1, 8'd0, 1'b0, 1'b1},  // R8 FIFO full throughout
        '{16'd4,  8'd0, 8'd0, 1'b0, 8'd2, 1'b0, 1'b0}   // R8 flag cleared at start
    };

    task automatic clear_mon();
        mon_words = 0; mon_dones = 0; mon_first = 1'b1; mon_done_wr = 1'b0;
    endtask

    task automatic run_cap(input vec_t v);
        int n_edges;
        n_edges = int'(v.tgt >> 1) + 4;
        clear_mon();
        @(posedge clk); #1;
        fifo_full = v.full; target_count = v.tgt; cap_en = 1'b1;
        @(posedge clk);                       // arming edge
        for (int k = 1; k <= n_edges; k++) begin
            #1;
            force_stop = (k == int'(v.stop_at));
            if (k == int'(v.drop_at)) cap_en = 1'b0;
            @(posedge clk);
        end
        #1; force_stop = 1'b0; cap_en = 1'b0; fifo_full = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(mon_words == int'(v.exp_words), "R4,R6,R7,R8,R10 word count",
            32'(mon_words), 32'(v.exp_words));
        chk(mon_dones == 1, "R5 one done pulse", 32'(mon_dones), 32'd1);
        chk(mon_done_wr == (v.exp_words != 0), "R5 done with final write",
            32'(mon_done_wr), 32'(v.exp_words != 0));
        chk(stopped_early == v.exp_early, "R6,R7,R10 early status",
            32'(stopped_early), 32'(v.exp_early));
        chk(overflow == v.exp_ovf, "R8 overflow flag", 32'(overflow), 32'(v.exp_ovf));
    endtask

    initial begin
        clear_mon();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(fifo_wr == 1'b0,       "R9 fifo_wr",       32'(fifo_wr),       32'd0);
        chk(cap_done == 1'b0,      "R9 cap_done",      32'(cap_done),      32'd0);
        chk(stopped_early == 1'b0, "R9 stopped_early", 32'(stopped_early), 32'd0);
        chk(overflow == 1'b0,      "R9 overflow",      32'(overflow),      32'd0);

        for (int i = 0; i < NV; i++) run_cap(VECS[i]);

        // R3 and R4: target changed after arming, enable held high long after done
        clear_mon();
        @(posedge clk); #1;
        target_count = 16'd4; cap_en = 1'b1;
        @(posedge clk); #1;
        target_count = 16'd40;
        repeat (14) @(posedge clk);
        @(negedge clk);
        chk(mon_words == 2, "R4 target latched at start", 32'(mon_words), 32'd2);
        chk(mon_dones == 1, "R3 no restart while enable held", 32'(mon_dones), 32'd1);
        #1 cap_en = 1'b0;

        // R3: re-arming after the enable drops works again
        run_cap('{16'd6, 8'd0, 8'd0, 1'b0, 8'd3, 1'b0, 1'b0});

        summary();
        $finish;
    end

endmodule